// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a 32-bit downstream peripheral bus through three 64-bit registers. The host writes a data word, then writes a control word that carries a fixed magic nibble, a transfer size, a read/write flag and a 32-bit address. That control write starts one downstream transaction. The host then polls a status word. Polling ends when the completion flag is set. The status word then gives any errors and, for a read, the returned value.

All register fields use big-endian bit numbering: bit 0 is the MSB of the 64-bit word. The register offsets are 0 for control, 2 for status and 3 for data. Control fields: magic nibble in bits 0-3 (must be 0xD), size in bytes in bits 4-7, read flag in bit 15, address length in bits 23-25 (4 means a 4-byte address), address in bits 32-63. Status fields: a 6-bit bus-error group in bits 0-5, the read-data field in bits 6-37, busy in bit 44, a 7-bit error group in bits 45-51, done in bit 52, and a 3-bit error group in bits 53-55.

Write data is taken left-justified from the data register. Read data comes back left-justified in the status read field. A command with a bad magic nibble or an illegal size is rejected on the spot. A transaction that gets no response is closed by a response timer.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, the control, status and data registers all read as zero, and no downstream request is raised.
- R2: An accepted write presents the downstream bus with the leftmost bytes of the data register, right-aligned on `pb_wdata`. Size 1 takes data bits 63:56 (LSB numbering), size 2 takes 63:48 and size 4 takes 63:32. The address comes from control bits 32-63, and the size code (1, 2 or 4) appears on `pb_size`.
- R3: A read that completes without error puts the returned bytes left-justified in the status read field (big-endian bits 6-37). Size 1 returns `pb_rdata[7:0]` in the top 8 bits of that field, size 2 returns `pb_rdata[15:0]` in the top 16 bits, and size 4 fills the whole field.
- R4: An accepted control write raises `pb_req` and sets status busy (bit 44) from the next cycle on. Both stay set until a response or a timeout. While busy is set, done stays clear, and the address and direction on the bus stay stable.
- R5: A downstream acknowledge clears busy and sets done (bit 52), with all three error groups zero.
- R6: A control write whose magic nibble is not 0xD, or whose size is not 1, 2 or 4, sets done and error bit 55 in the next cycle. It raises no downstream request.
- R7: A downstream error response sets done and bus-error bit 5. For a read, the read field stays zero.
- R8: If no response arrives within `TIMEOUT_CYC` cycles of the launch, the bridge drops the request and sets done and timeout bit 51. Done becomes visible exactly `TIMEOUT_CYC` cycles after the launching edge.
- R9: An acknowledge that arrives in the last cycle of the timeout window completes the transaction as a success. An acknowledge one cycle later has no effect, and the timeout stands.
- R10: A control write while busy is ignored. The control register keeps its value, the transaction in flight goes on unchanged, and no second request is issued.
- R11: The next accepted control write clears done, all error bits and the read field.
- R12: The control and data registers read back the last value written to them. Offset 1 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register offset (0 control, 2 status, 3 data) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_sel` (combinational) |
| pb_req | output | 1 | Downstream request, held until a response or timeout |
| pb_we | output | 1 | Downstream direction, 1 for write |
| pb_addr | output | 32 | Downstream address |
| pb_wdata | output | 32 | Downstream write data, right-aligned |
| pb_size | output | 3 | Downstream size in bytes |
| pb_ack | input | 1 | Downstream acknowledge |
| pb_err | input | 1 | Downstream error response |
| pb_rdata | input | 32 | Downstream read data, right-aligned, valid with `pb_ack` |

## Verification
Two events can fall in the same cycle: the downstream acknowledge and the expiry of the response timer. To provoke this, the responder delays its acknowledge so that it is sampled on exactly the `TIMEOUT_CYC`-th edge after launch. In that case the bench expects a clean success with done set after that many polls. A second run delays the acknowledge by one more cycle, and there the bench expects the timeout bit with no second completion. A control write issued while busy shares cycles with the live request. The bench judges that case by reading back the control register, sampling `pb_addr`, and checking that the scoreboard sees only one downstream cycle.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

  localparam int WORD_W = 64;
  localparam int PB_AW  = 32;
  localparam int PB_DW  = 32;
  localparam int SEL_W  = 2;

  // map a big-endian bit number onto an LSB-based index
  function automatic int be_pos(input int b);
    return WORD_W - 1 - b;
  endfunction

  // control word fields
  localparam int C_MAGIC_MSB = be_pos(0);
  localparam int C_MAGIC_LSB = be_pos(3);
  localparam int C_SIZE_MSB  = be_pos(4);
  localparam int C_SIZE_LSB  = be_pos(7);
  localparam int C_READ      = be_pos(15);
  localparam int C_ADDR_MSB  = be_pos(32);
  localparam int C_ADDR_LSB  = be_pos(63);

  // status word fields
  localparam int S_BERR_MSB  = be_pos(0);
  localparam int S_BERR_LSB  = be_pos(5);
  localparam int S_RD_MSB    = be_pos(6);
  localparam int S_RD_LSB    = be_pos(37);
  localparam int S_BUSY      = be_pos(44);
  localparam int S_ERR1_MSB  = be_pos(45);
  localparam int S_ERR1_LSB  = be_pos(51);
  localparam int S_DONE      = be_pos(52);
  localparam int S_ERR2_MSB  = be_pos(53);
  localparam int S_ERR2_LSB  = be_pos(55);
  localparam int S_BUSERR    = be_pos(5);
  localparam int S_TMO       = be_pos(51);
  localparam int S_REJ       = be_pos(55);

  localparam logic [3:0]       MAGIC    = 4'hD;
  localparam logic [SEL_W-1:0] SEL_CTL  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_STAT = 2'd2;
  localparam logic [SEL_W-1:0] SEL_DATA = 2'd3;

  typedef struct packed {
    logic             rd;
    logic [PB_AW-1:0] addr;
    logic [2:0]       size;
    logic [PB_DW-1:0] wdata;
  } ibr_cmd_t;

  typedef enum logic {ENG_IDLE, ENG_WAIT} ibr_eng_state_t;

endpackage

// File: rtl/ibr_ctl_decode.sv
module ibr_ctl_decode
  import ibr_pkg::*;
(
  input  logic [WORD_W-1:0] ctl_word,
  input  logic [WORD_W-1:0] data_word,
  output ibr_cmd_t          cmd,
  output logic              legal
);

  logic [3:0] magic_f;
  logic [3:0] size_f;

  always_comb begin
    magic_f   = ctl_word[C_MAGIC_MSB:C_MAGIC_LSB];
    size_f    = ctl_word[C_SIZE_MSB:C_SIZE_LSB];
    cmd.rd    = ctl_word[C_READ];
    cmd.addr  = ctl_word[C_ADDR_MSB:C_ADDR_LSB];
    cmd.size  = size_f[2:0];
    cmd.wdata = '0;
    legal     = (magic_f == MAGIC);
    case (size_f)
      4'd1: cmd.wdata = {{(PB_DW-8){1'b0}},  data_word[WORD_W-1 -: 8]};
      4'd2: cmd.wdata = {{(PB_DW-16){1'b0}}, data_word[WORD_W-1 -: 16]};
      4'd4: cmd.wdata = data_word[WORD_W-1 -: PB_DW];
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/ibr_engine.sv
module ibr_engine
  import ibr_pkg::*;
#(
  parameter int TIMEOUT_CYC = 32
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             legal,
  input  ibr_cmd_t         cmd_in,
  input  logic             pb_ack,
  input  logic             pb_err,
  input  logic [PB_DW-1:0] pb_rdata,
  output logic             pb_req,
  output ibr_cmd_t         cmd_q,
  output logic             busy,
  output logic             done,
  output logic             berr,
  output logic             tmo,
  output logic             rej,
  output logic [PB_DW-1:0] rdat
);

  localparam int               CNT_W    = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  ibr_eng_state_t   state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  ibr_cmd_t         cmd_d;
  logic             done_q, done_d, berr_q, berr_d;
  logic             tmo_q, tmo_d, rej_q, rej_d;
  logic [PB_DW-1:0] rdat_q, rdat_d, rd_masked;
  logic             upd_en;

  always_comb begin
    case (cmd_q.size)
      3'd1:    rd_masked = {{(PB_DW-8){1'b0}},  pb_rdata[7:0]};
      3'd2:    rd_masked = {{(PB_DW-16){1'b0}}, pb_rdata[15:0]};
      default: rd_masked = pb_rdata;
    endcase
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cmd_d   = cmd_q;
    done_d  = done_q;
    berr_d  = berr_q;
    tmo_d   = tmo_q;
    rej_d   = rej_q;
    rdat_d  = rdat_q;
    unique case (state_q)
      ENG_IDLE: begin
        if (launch) begin
          done_d = 1'b0;
          berr_d = 1'b0;
          tmo_d  = 1'b0;
          rej_d  = 1'b0;
          rdat_d = '0;
          cmd_d  = cmd_in;
          if (legal) begin
            state_d = ENG_WAIT;
            cnt_d   = '0;
          end else begin
            done_d = 1'b1;
            rej_d  = 1'b1;
          end
        end
      end
      ENG_WAIT: begin
        if (pb_ack || pb_err) begin
          state_d = ENG_IDLE;
          done_d  = 1'b1;
          berr_d  = pb_err;
          if (cmd_q.rd && !pb_err) rdat_d = rd_masked;
        end else if (cnt_q == CNT_LAST) begin
          state_d = ENG_IDLE;
          done_d  = 1'b1;
          tmo_d   = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  assign upd_en = launch || (state_q == ENG_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
      cmd_q   <= '0;
      done_q  <= 1'b0;
      berr_q  <= 1'b0;
      tmo_q   <= 1'b0;
      rej_q   <= 1'b0;
      rdat_q  <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cmd_q   <= cmd_d;
      done_q  <= done_d;
      berr_q  <= berr_d;
      tmo_q   <= tmo_d;
      rej_q   <= rej_d;
      rdat_q  <= rdat_d;
    end
  end

  assign pb_req = (state_q == ENG_WAIT);
  assign busy   = pb_req;
  assign done   = done_q;
  assign berr   = berr_q;
  assign tmo    = tmo_q;
  assign rej    = rej_q;
  assign rdat   = rdat_q;

endmodule

// File: rtl/ibr_status_pack.sv
module ibr_status_pack
  import ibr_pkg::*;
(
  input  logic              busy,
  input  logic              done,
  input  logic              berr,
  input  logic              tmo,
  input  logic              rej,
  input  logic [2:0]        size,
  input  logic [PB_DW-1:0]  rdat,
  output logic [WORD_W-1:0] status
);

  logic [PB_DW-1:0] rd_left;

  always_comb begin
    case (size)
      3'd1:    rd_left = {rdat[7:0],  {(PB_DW-8){1'b0}}};
      3'd2:    rd_left = {rdat[15:0], {(PB_DW-16){1'b0}}};
      default: rd_left = rdat;
    endcase
    status                       = '0;
    status[S_RD_MSB:S_RD_LSB]    = rd_left;
    status[S_BUSY]               = busy;
    status[S_DONE]               = done;
    status[S_BUSERR]             = berr;
    status[S_TMO]                = tmo;
    status[S_REJ]                = rej;
  end

endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ibr_pkg::*;
#(
  parameter int TIMEOUT_CYC = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              pb_req,
  output logic              pb_we,
  output logic [PB_AW-1:0]  pb_addr,
  output logic [PB_DW-1:0]  pb_wdata,
  output logic [2:0]        pb_size,
  input  logic              pb_ack,
  input  logic              pb_err,
  input  logic [PB_DW-1:0]  pb_rdata
);

  logic [WORD_W-1:0] ctl_q, data_q, status_w;
  logic              ctl_we, data_we, busy, done, berr, tmo, rej, legal;
  logic [PB_DW-1:0]  rdat;
  ibr_cmd_t          cmd_dec, cmd_q;

  assign ctl_we  = reg_wr && (reg_sel == SEL_CTL) && !busy;
  assign data_we = reg_wr && (reg_sel == SEL_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_we) data_q <= reg_wdata;
  end

  ibr_ctl_decode u_dec (
    .ctl_word  (reg_wdata),
    .data_word (data_q),
    .cmd       (cmd_dec),
    .legal     (legal)
  );

  ibr_engine #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (ctl_we),
    .legal    (legal),
    .cmd_in   (cmd_dec),
    .pb_ack   (pb_ack),
    .pb_err   (pb_err),
    .pb_rdata (pb_rdata),
    .pb_req   (pb_req),
    .cmd_q    (cmd_q),
    .busy     (busy),
    .done     (done),
    .berr     (berr),
    .tmo      (tmo),
    .rej      (rej),
    .rdat     (rdat)
  );

  ibr_status_pack u_pack (
    .busy   (busy),
    .done   (done),
    .berr   (berr),
    .tmo    (tmo),
    .rej    (rej),
    .size   (cmd_q.size),
    .rdat   (rdat),
    .status (status_w)
  );

  assign pb_we    = !cmd_q.rd;
  assign pb_addr  = cmd_q.addr;
  assign pb_wdata = cmd_q.wdata;
  assign pb_size  = cmd_q.size;

  always_comb begin
    case (reg_sel)
      SEL_CTL:  reg_rdata = ctl_q;
      SEL_STAT: reg_rdata = status_w;
      SEL_DATA: reg_rdata = data_q;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ibr_checker.sv
module ibr_checker
  import ibr_pkg::*;
#(
  parameter int TIMEOUT_CYC = 32
)(
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  reg_sel,
  input logic              reg_wr,
  input logic [WORD_W-1:0] reg_wdata,
  input logic [WORD_W-1:0] status_w,
  input logic              pb_req,
  input logic              pb_we,
  input logic [PB_AW-1:0]  pb_addr
);

  localparam int CW = $clog2(TIMEOUT_CYC + 2);

  logic [CW-1:0] req_run;
  logic          ctl_free, cmd_bad;
  logic [3:0]    sz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_run <= '0;
    else if (pb_req) req_run <= req_run + 1'b1;
    else             req_run <= '0;
  end

  assign sz       = reg_wdata[C_SIZE_MSB:C_SIZE_LSB];
  assign ctl_free = reg_wr && (reg_sel == SEL_CTL) && !status_w[S_BUSY];
  assign cmd_bad  = (reg_wdata[C_MAGIC_MSB:C_MAGIC_LSB] != MAGIC) ||
                    !((sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4));

  // R4: a request only ever starts after a control write
  assert_launch_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pb_req) |-> $past(reg_wr && (reg_sel == SEL_CTL)));

  // R4: busy and done never coexist
  assert_busy_not_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status_w[S_BUSY] |-> !status_w[S_DONE]);

  // R10: command on the bus is held while the request stays up
  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_req && $past(pb_req)) |-> ($stable(pb_addr) && $stable(pb_we)));

  // R6: rejected command finishes at once without a bus cycle
  assert_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_free && cmd_bad) |=> (!pb_req && status_w[S_DONE] && status_w[S_REJ]));

  // R11: a legal launch clears done and starts a request
  assert_launch_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_free && !cmd_bad) |=> (pb_req && !status_w[S_DONE]));

  // R8: request never outlives the timeout window
  assert_tmo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_run <= CW'(TIMEOUT_CYC));

endmodule

bind ind_reg_bridge ibr_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .status_w  (status_w),
  .pb_req    (pb_req),
  .pb_we     (pb_we),
  .pb_addr   (pb_addr)
);

// File: tb/ind_reg_bridge_test.sv
module ind_reg_bridge_test;

  localparam int TMO = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_sel;
  logic        reg_wr;
  logic [63:0] reg_wdata, reg_rdata;
  logic        pb_req, pb_we, pb_ack, pb_err;
  logic [31:0] pb_addr, pb_wdata, pb_rdata;
  logic [2:0]  pb_size;

  always #4 clk = ~clk;

  ind_reg_bridge #(.TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pb_req(pb_req),
    .pb_we(pb_we), .pb_addr(pb_addr), .pb_wdata(pb_wdata), .pb_size(pb_size),
    .pb_ack(pb_ack), .pb_err(pb_err), .pb_rdata(pb_rdata)
  );

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [2:0]  size;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  int          checks = 0;
  int          errors = 0;
  int          resp_kind = 0;   // 0 ack, 1 error, 2 silent
  int          resp_delay = 0;
  logic [31:0] resp_data = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] st_exp(logic [5:0] be, logic [31:0] rd, logic busy,
                                         logic [6:0] e1, logic done, logic [2:0] e2);
    return {be, rd, 6'b0, busy, e1, done, e2, 8'b0};
  endfunction

  function automatic logic [63:0] ctl(logic [3:0] magic, logic [3:0] size, logic rd, logic [31:0] addr);
    return {magic, size, 7'b0, rd, 7'b0, 3'd4, 6'b0, addr};
  endfunction

  task automatic wr_reg(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [63:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic poll(output logic [63:0] st, output int n);
    n = 0; st = '0;
    while (!st[11] && n < 500) begin
      rd_reg(2'd2, st);
      n++;
    end
  endtask

  task automatic run_op(input bit rd, input logic [3:0] size, input logic [31:0] addr,
                        input logic [63:0] dreg, input logic [31:0] wexp, input int kind,
                        input int dly, input logic [31:0] rdv, input string tag,
                        output logic [63:0] st, output int n);
    exp_t e;
    wr_reg(2'd3, dreg);
    e.we = !rd; e.addr = addr; e.wdata = wexp; e.size = size[2:0]; e.tag = tag;
    exp_q.push_back(e);
    resp_kind = kind; resp_delay = dly; resp_data = rdv;
    wr_reg(2'd0, ctl(4'hD, size, rd, addr));
    poll(st, n);
  endtask

  // monitor and responder: pops the scoreboard on every new request
  initial begin
    bit active = 0;
    int cnt = 0;
    exp_t e;
    pb_ack = 1'b0; pb_err = 1'b0; pb_rdata = '0;
    forever begin
      @(negedge clk);
      pb_ack = 1'b0; pb_err = 1'b0;
      if (rst_n === 1'b1 && pb_req && !active) begin
        active = 1; cnt = 0;
        if (exp_q.size() == 0) begin
          chk(0, "R6/R10 unexpected downstream cycle", {32'b0, pb_addr}, 64'b0);
        end else begin
          e = exp_q.pop_front();
          chk(pb_addr == e.addr && pb_we == e.we && pb_size == e.size &&
              (!e.we || pb_wdata == e.wdata), e.tag,
              {pb_we, pb_size, pb_addr, pb_wdata[27:0]}, {e.we, e.size, e.addr, e.wdata[27:0]});
        end
      end
      if (active) begin
        if (!pb_req) active = 0;
        else begin
          if (cnt == resp_delay && resp_kind != 2) begin
            if (resp_kind == 1) pb_err = 1'b1;
            else                pb_ack = 1'b1;
            pb_rdata = resp_data;
          end
          cnt++;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 64'b0, 64'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] st, d;
    int n;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd_reg(2'd2, st); chk(st == 64'b0, "R1 status reset", st, 64'b0);
    rd_reg(2'd0, d);  chk(d == 64'b0, "R1 control reset", d, 64'b0);
    rd_reg(2'd3, d);  chk(d == 64'b0 && pb_req == 1'b0, "R1 data reset / no request", d, 64'b0);

    // 4-byte write with busy observation
    wr_reg(2'd3, 64'h11223344_55667788);
    rd_reg(2'd3, d); chk(d == 64'h11223344_55667788, "R12 data readback", d, 64'h11223344_55667788);
    begin
      exp_t e;
      e.we = 1; e.addr = 32'h100; e.wdata = 32'h11223344; e.size = 3'd4; e.tag = "R2 size4 write";
      exp_q.push_back(e);
    end
    resp_kind = 0; resp_delay = 3;
    wr_reg(2'd0, ctl(4'hD, 4'd4, 1'b0, 32'h100));
    rd_reg(2'd2, st);
    chk(st == st_exp(0, 0, 1, 0, 0, 0) && pb_req, "R4 busy while waiting", st, st_exp(0, 0, 1, 0, 0, 0));
    poll(st, n);
    chk(st == st_exp(0, 0, 0, 0, 1, 0), "R5 done clean", st, st_exp(0, 0, 0, 0, 1, 0));
    rd_reg(2'd0, d); chk(d == ctl(4'hD, 4'd4, 1'b0, 32'h100), "R12 control readback", d, ctl(4'hD, 4'd4, 1'b0, 32'h100));
    rd_reg(2'd1, d); chk(d == 64'b0, "R12 offset 1 zero", d, 64'b0);

    // narrow writes
    run_op(0, 4'd1, 32'h200, 64'hA5FF0000_00000000, 32'h000000A5, 0, 0, 0, "R2 size1 write", st, n);
    chk(st == st_exp(0, 0, 0, 0, 1, 0), "R2 size1 done", st, st_exp(0, 0, 0, 0, 1, 0));
    run_op(0, 4'd2, 32'h202, 64'hBEEF7777_00000000, 32'h0000BEEF, 0, 2, 0, "R2 size2 write", st, n);
    chk(st == st_exp(0, 0, 0, 0, 1, 0), "R2 size2 done", st, st_exp(0, 0, 0, 0, 1, 0));

    // reads
    run_op(1, 4'd4, 32'h300, 64'h0, 32'h0, 0, 1, 32'hCAFEF00D, "R3 size4 read", st, n);
    chk(st == st_exp(0, 32'hCAFEF00D, 0, 0, 1, 0), "R3 size4 data", st, st_exp(0, 32'hCAFEF00D, 0, 0, 1, 0));
    run_op(1, 4'd1, 32'h301, 64'h0, 32'h0, 0, 0, 32'h123456AB, "R3 size1 read", st, n);
    chk(st == st_exp(0, 32'hAB000000, 0, 0, 1, 0), "R3 size1 data", st, st_exp(0, 32'hAB000000, 0, 0, 1, 0));
    run_op(1, 4'd2, 32'h302, 64'h0, 32'h0, 0, 5, 32'h1234BEEF, "R3 size2 read", st, n);
    chk(st == st_exp(0, 32'hBEEF0000, 0, 0, 1, 0), "R3 size2 data", st, st_exp(0, 32'hBEEF0000, 0, 0, 1, 0));

    // rejected commands
    wr_reg(2'd0, ctl(4'hE, 4'd4, 1'b0, 32'h400));
    rd_reg(2'd2, st);
    chk(st == st_exp(0, 0, 0, 0, 1, 3'b001), "R6 bad magic", st, st_exp(0, 0, 0, 0, 1, 3'b001));
    wr_reg(2'd0, ctl(4'hD, 4'd3, 1'b1, 32'h404));
    rd_reg(2'd2, st);
    chk(st == st_exp(0, 0, 0, 0, 1, 3'b001), "R6 bad size", st, st_exp(0, 0, 0, 0, 1, 3'b001));
    repeat (4) @(negedge clk);
    chk(pb_req == 1'b0 && exp_q.size() == 0, "R6 no downstream cycle", {63'b0, pb_req}, 64'b0);

    // next accepted launch clears previous state
    begin
      exp_t e;
      e.we = 0; e.addr = 32'h500; e.wdata = 0; e.size = 3'd4; e.tag = "R11 relaunch";
      exp_q.push_back(e);
    end
    resp_kind = 0; resp_delay = 4; resp_data = 32'h0BADBEEF;
    wr_reg(2'd0, ctl(4'hD, 4'd4, 1'b1, 32'h500));
    rd_reg(2'd2, st);
    chk(st == st_exp(0, 0, 1, 0, 0, 0), "R11 cleared on launch", st, st_exp(0, 0, 1, 0, 0, 0));
    poll(st, n);
    chk(st == st_exp(0, 32'h0BADBEEF, 0, 0, 1, 0), "R11 relaunch result", st, st_exp(0, 32'h0BADBEEF, 0, 0, 1, 0));

    // downstream error
    run_op(1, 4'd4, 32'h600, 64'h0, 32'h0, 1, 2, 32'hFFFFFFFF, "R7 error read", st, n);
    chk(st == st_exp(6'b000001, 0, 0, 0, 1, 0), "R7 bus error", st, st_exp(6'b000001, 0, 0, 0, 1, 0));

    // timeout with no response
    run_op(0, 4'd4, 32'h700, 64'h0, 32'h0, 2, 0, 0, "R8 silent write", st, n);
    chk(st == st_exp(0, 0, 0, 7'b0000001, 1, 0), "R8 timeout bit", st, st_exp(0, 0, 0, 7'b0000001, 1, 0));
    chk(n == TMO, "R8 timeout latency", 64'(n), 64'(TMO));

    // ack on the last window cycle, then one cycle late
    run_op(1, 4'd4, 32'h800, 64'h0, 32'h0, 0, TMO - 1, 32'h5A5A1234, "R9 last-cycle read", st, n);
    chk(st == st_exp(0, 32'h5A5A1234, 0, 0, 1, 0) && n == TMO, "R9 last-cycle ack wins",
        st, st_exp(0, 32'h5A5A1234, 0, 0, 1, 0));
    run_op(1, 4'd4, 32'h804, 64'h0, 32'h0, 0, TMO, 32'h5A5A1234, "R9 late read", st, n);
    chk(st == st_exp(0, 0, 0, 7'b0000001, 1, 0), "R9 late ack ignored", st, st_exp(0, 0, 0, 7'b0000001, 1, 0));
    repeat (3) @(negedge clk);
    rd_reg(2'd2, d);
    chk(d == st, "R9 status unchanged after late ack", d, st);

    // control write while busy
    begin
      exp_t e;
      e.we = 0; e.addr = 32'h900; e.wdata = 0; e.size = 3'd2; e.tag = "R10 in-flight read";
      exp_q.push_back(e);
    end
    resp_kind = 0; resp_delay = 10; resp_data = 32'h0000C0DE;
    wr_reg(2'd0, ctl(4'hD, 4'd2, 1'b1, 32'h900));
    wr_reg(2'd0, ctl(4'hD, 4'd4, 1'b0, 32'hA00));
    rd_reg(2'd0, d);
    chk(d == ctl(4'hD, 4'd2, 1'b1, 32'h900), "R10 control kept", d, ctl(4'hD, 4'd2, 1'b1, 32'h900));
    chk(pb_addr == 32'h900 && pb_req, "R10 bus address kept", {32'b0, pb_addr}, 64'h900);
    poll(st, n);
    chk(st == st_exp(0, 32'hC0DE0000, 0, 0, 1, 0), "R10 in-flight result", st, st_exp(0, 32'hC0DE0000, 0, 0, 1, 0));
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && !pb_req, "R10 single downstream cycle", 64'(exp_q.size()), 64'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule